// File: doc/BRIEF.md
# Polled Coprocessor Command/Response Port

This block sits on a processor's ordinary peripheral bus and stands in for the dedicated coprocessor bus cycles that the processor lacks. A software handler writes a 16-bit command word, polls a response word until the block is ready, moves a 64-bit double-precision operand as two 32-bit words, and then polls again until the response shows that the operation is finished. Behind the port sit eight 64-bit floating-point registers.

Only plain double-precision moves are carried out: memory-to-register (load) and register-to-memory (store). Any other command is accepted and released at once, with no effect on the registers. The block has three byte offsets: response, command and operand. The response takes one of three values: busy (`0x8900`), transfer request (`0x9504`) and released/idle (`0x0802`, bit 15 clear).

Top module: `fpcp_mmio`

## Requirements
- R1: Offsets: response at 0x00, command at 0x0A, operand at 0x10. A read of the response offset returns the response in rdata[15:0] with rdata[31:16] zero. Reads of the command offset or of any other offset return zero.
- R2: Command word fields: bits 15:14 = 01; bit 13 gives the direction (0 load, 1 store); bits 12:10 = 101 select double format; bits 9:7 give the register number 0..7; bits 6:0 give the opmode. A command is supported only when bits 15:14, bits 12:10 and the opmode (0 = move) all match.
- R3: After a supported command write, the response reads 0x8900 for exactly WAIT_CYC cycles and then reads 0x9504.
- R4: In a load, the first operand write is the high longword and the second is the low longword. After the second write, the selected register holds {high, low} and the response becomes 0x0802. No other operation changes a register.
- R5: In a store, the first operand read returns the high longword of the selected register and the second returns the low longword. The response then becomes 0x0802.
- R6: A command that is not supported sets the response to 0x0802 in the cycle after the write and leaves all registers unchanged.
- R7: An operand access outside the transfer phase, or against the direction of the current command, has no effect. A write of this kind is ignored and a read of this kind returns zero.
- R8: Synchronous active-high reset clears all eight registers and sets the response to 0x0802.
- R9: A command write in any state abandons the transfer in progress and starts the new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte offset from the port base |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; the access is consumed at the clock edge |
| wdata | input | 32 | Write data; commands use bits 15:0 |
| rdata | output | 32 | Read data for the current address (combinational) |

## Verification
The bench counts the busy polls between a command and the transfer request. A design with an off-by-one wait shows WAIT_CYC±1 busy reads. It loads all eight registers with distinct patterns and stores them back, which exposes swapped longword order, a wrong register field slice and a swapped direction bit. It sweeps all 127 non-move opmodes and several corrupted format fields, and it performs stray operand accesses while idle, while busy and against the current direction; a design that decoded too loosely would change a register or return nonzero data. It also abandons a half-finished load with a new command, which catches a design that keeps the stale longword phase.

// File: rtl/fpcp_mmio.sv
module fpcp_mmio #(
  parameter int WAIT_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [15:0] RSP_IDLE = 16'h0802;
  localparam logic [15:0] RSP_BUSY = 16'h8900;
  localparam logic [15:0] RSP_XFER = 16'h9504;
  localparam logic [4:0]  OFF_RSP  = 5'h00;
  localparam logic [4:0]  OFF_CMD  = 5'h0A;
  localparam logic [4:0]  OFF_OPD  = 5'h10;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_XFER} st_t;

  st_t              st;
  logic [7:0][63:0] fpr;
  logic [2:0]       sel;
  logic             dir;
  logic             half;
  logic [31:0]      hi_hold;
  logic [CW-1:0]    cnt;
  logic [15:0]      resp;

  wire cmd_wr = wr_en && addr == OFF_CMD;
  wire cmd_ok = wdata[15:14] == 2'b01 && wdata[12:10] == 3'b101 && wdata[6:0] == 7'd0;
  wire op_wr  = wr_en && addr == OFF_OPD && st == S_XFER && !dir;
  wire op_rd  = rd_en && addr == OFF_OPD && st == S_XFER && dir;

  assign resp = (st == S_BUSY) ? RSP_BUSY : (st == S_XFER) ? RSP_XFER : RSP_IDLE;

  always_comb begin
    rdata = 32'd0;
    if (addr == OFF_RSP)
      rdata = {16'd0, resp};
    else if (addr == OFF_OPD && st == S_XFER && dir)
      rdata = half ? fpr[sel][31:0] : fpr[sel][63:32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      fpr     <= '0;
      sel     <= '0;
      dir     <= 1'b0;
      half    <= 1'b0;
      hi_hold <= '0;
      cnt     <= '0;
    end else if (cmd_wr) begin
      sel  <= wdata[9:7];
      dir  <= wdata[13];
      half <= 1'b0;
      cnt  <= CW'(WAIT_CYC - 1);
      st   <= cmd_ok ? S_BUSY : S_IDLE;
    end else begin
      case (st)
        S_BUSY:
          if (cnt == '0) st <= S_XFER;
          else cnt <= cnt - 1'b1;
        S_XFER:
          if (op_wr) begin
            if (!half) begin
              hi_hold <= wdata;
              half    <= 1'b1;
            end else begin
              fpr[sel] <= {hi_hold, wdata};
              st       <= S_IDLE;
            end
          end else if (op_rd) begin
            if (!half) half <= 1'b1;
            else st <= S_IDLE;
          end
        default: ;
      endcase
    end
  end
endmodule

module fpcp_mmio_chk (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       addr,
  input logic             wr_en,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [15:0]      resp,
  input logic [7:0][63:0] fpr
);
  wire cmd_w  = wr_en && addr == 5'h0A;
  wire good_c = wdata[15:14] == 2'b01 && wdata[12:10] == 3'b101 && wdata[6:0] == 7'd0;

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (resp == 16'h0802 && fpr == '0));

  assert_busy_after_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && good_c) |=> resp == 16'h8900);

  assert_unsupported_release_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && !good_c) |=> (resp == 16'h0802 && $stable(fpr)));

  assert_resp_codes_R2: assert property (@(posedge clk) disable iff (rst)
    resp == 16'h0802 || resp == 16'h8900 || resp == 16'h9504);

  assert_stray_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (addr == 5'h10 && resp != 16'h9504) |-> rdata == 32'd0);

  assert_regs_only_on_load_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 5'h10 && resp == 16'h9504) |=> $stable(fpr));

  assert_high_half_zero_R1: assert property (@(posedge clk) disable iff (rst)
    addr == 5'h00 |-> rdata[31:16] == 16'd0);
endmodule

bind fpcp_mmio fpcp_mmio_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .resp(resp), .fpr(fpr)
);

// File: tb/sim_fpcp_mmio.sv
module sim_fpcp_mmio;
  localparam int WAITC = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int total = 0, bad = 0;
  bit done = 0;

  fpcp_mmio #(.WAIT_CYC(WAITC)) u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic poll(output int nbusy, output logic [31:0] last);
    nbusy = 0;
    brd(5'h00, last);
    while (last == 32'h8900 && nbusy < 100) begin
      nbusy++;
      brd(5'h00, last);
    end
  endtask

  function automatic logic [15:0] cmdw(input bit st, input int r, input int opm);
    return 16'h5400 | (st ? 16'h2000 : 16'h0) | 16'(r << 7) | 16'(opm);
  endfunction

  function automatic logic [63:0] pat(input int r, input int k);
    return {32'hA5000000 ^ (32'h01010101 * (r + 1)) ^ k, 32'h0F0F1230 + 32'(r * 97 + k)};
  endfunction

  task automatic do_load(input int r, input logic [63:0] v, input string req);
    int n; logic [31:0] x;
    bwr(5'h0A, 32'(cmdw(0, r, 0)));
    poll(n, x);
    chk(n == WAITC, "R3 busy polls", 64'(n), 64'(WAITC));
    chk(x == 32'h9504, "R3 xfer code", 64'(x), 64'h9504);
    bwr(5'h10, v[63:32]);
    bwr(5'h10, v[31:0]);
    brd(5'h00, x);
    chk(x == 32'h0802, req, 64'(x), 64'h0802);
  endtask

  task automatic do_store(input int r, output logic [63:0] v);
    int n; logic [31:0] x, h, l;
    bwr(5'h0A, 32'(cmdw(1, r, 0)));
    poll(n, x);
    brd(5'h10, h);
    brd(5'h10, l);
    v = {h, l};
    brd(5'h00, x);
    chk(x == 32'h0802, "R5 release after store", 64'(x), 64'h0802);
  endtask

  initial begin
    logic [31:0] x;
    logic [63:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    brd(5'h00, x);
    chk(x == 32'h0802, "R8 reset response", 64'(x), 64'h0802);
    do_store(3, v);
    chk(v == 64'd0, "R8 reset register zero", v, 64'd0);

    for (int r = 0; r < 8; r++) do_load(r, pat(r, 0), "R4 release after load");
    for (int r = 0; r < 8; r++) begin
      do_store(r, v);
      chk(v == pat(r, 0), "R4/R5/R2 load-store round trip", v, pat(r, 0));
    end

    for (int m = 1; m < 128; m++) begin
      bwr(5'h0A, 32'(cmdw(m[0], m % 8, m)));
      brd(5'h00, x);
      chk(x == 32'h0802, "R6 unsupported opmode released", 64'(x), 64'h0802);
    end
    bwr(5'h0A, 32'h5000);
    brd(5'h00, x);
    chk(x == 32'h0802, "R6/R2 bad format field", 64'(x), 64'h0802);
    bwr(5'h0A, 32'h1400);
    brd(5'h00, x);
    chk(x == 32'h0802, "R6/R2 bad top bits", 64'(x), 64'h0802);
    bwr(5'h0A, 32'h5401);
    bwr(5'h10, 32'hDEAD0001);
    bwr(5'h10, 32'hDEAD0002);
    for (int r = 0; r < 8; r++) begin
      do_store(r, v);
      chk(v == pat(r, 0), "R6 registers unchanged", v, pat(r, 0));
    end

    bwr(5'h10, 32'h11111111);
    brd(5'h10, x);
    chk(x == 32'd0, "R7 idle operand read zero", 64'(x), 64'd0);
    bwr(5'h0A, 32'(cmdw(0, 2, 0)));
    bwr(5'h10, 32'h22222222);
    brd(5'h10, x);
    chk(x == 32'd0, "R7 busy operand read zero", 64'(x), 64'd0);
    poll(n, x);
    brd(5'h10, x);
    chk(x == 32'd0, "R7 read during load zero", 64'(x), 64'd0);
    bwr(5'h10, 32'hCAFE0000);
    bwr(5'h10, 32'h0000BEEF);
    do_store(2, v);
    chk(v == 64'hCAFE00000000BEEF, "R7 stray writes ignored", v, 64'hCAFE00000000BEEF);
    bwr(5'h0A, 32'(cmdw(1, 5, 0)));
    poll(n, x);
    bwr(5'h10, 32'h33333333);
    brd(5'h10, x);
    chk(x == pat(5, 0)[63:32], "R7 write during store ignored", 64'(x), 64'(pat(5, 0)[63:32]));
    brd(5'h10, x);

    bwr(5'h0A, 32'(cmdw(0, 6, 0)));
    poll(n, x);
    bwr(5'h10, 32'h44444444);
    do_load(6, pat(6, 7), "R9 restarted load release");
    do_store(6, v);
    chk(v == pat(6, 7), "R9 restart longword phase", v, pat(6, 7));

    brd(5'h0A, x);
    chk(x == 32'd0, "R1 command offset reads zero", 64'(x), 64'd0);
    brd(5'h04, x);
    chk(x == 32'd0, "R1 unmapped offset reads zero", 64'(x), 64'd0);
    bwr(5'h0A, 32'(cmdw(1, 1, 0)));
    brd(5'h00, x);
    chk(x == 32'h00008900, "R1 response in low half", 64'(x), 64'h8900);

    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    brd(5'h00, x);
    chk(x == 32'h0802, "R8 mid-run reset response", 64'(x), 64'h0802);
    do_store(0, v);
    chk(v == 64'd0, "R8 mid-run reset clears", v, 64'd0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule